// File: doc/BRIEF.md
# Regulator Power-State Command Handler

This block sits on the responder side of a serial voltage-regulator control link. Its input is a command that has already been decoded: a type field, one payload byte and a valid strobe. For every command it returns a 2-bit acknowledge code. It keeps three pieces of state: the regulator's current power state, a target voltage code, and a modelled output voltage code that moves toward the target.

Downstream power-stage logic receives two enables, one for phase shedding and one for pulse skipping. Which power state is in force decides them. A parameter mask declares which low-power states the regulator supports. A request for any other state is refused and the power state is left as it is. A voltage-change command that raises the voltage while the regulator is in a low-power state returns it to full power at once.

Voltage slewing is modelled only as a register that steps one code per clock toward the target, together with a done flag. Serial framing, parity, bus turnaround and the analog loop are handled elsewhere.

Top module: `vr_pstate_handler`

## Requirements
- R1: After reset the power state is full power (code 0), the voltage target is 0, both enables are low, slewDone is high and ackValid is low.
- R2: A set-state command (cmdType 3'd2) whose payload is 8'h00, 8'h01 or 8'h02 names a supported state. It is acknowledged with 2'b00 and the power state takes that code.
- R3: phaseShedEn is high exactly while the state is light load (code 1). pulseSkipEn is high exactly while the state is very light load (code 2). The two are never high together.
- R4: The block refuses a set-state command with 2'b11 when its payload is above 8'h02, or when it names a low-power state cleared in LOW_PS_MASK (bit 0 covers code 1, bit 1 covers code 2). After a refusal the power state and voltage target are unchanged.
- R5: A command whose type is neither 3'd1 (set voltage) nor 3'd2 (set state) is answered with 2'b11 and changes no state.
- R6: A set-voltage command (cmdType 3'd1) whose payload is above the current target sets the target and forces the state to full power on the same edge, acknowledged with 2'b00.
- R7: A set-voltage command whose payload is equal to or below the current target updates the target and leaves the power state unchanged.
- R8: ackValid is high in exactly the cycle after each cmdValid cycle, including back-to-back commands. ackCode and the state outputs update on that same edge.
- R9: The modelled voltage moves one code per clock toward the target. slewDone is low while they differ, so a change of N codes from a settled point keeps slewDone low for N clocks.
- R10: Any pair among the three states may be reached directly, including full to very light and very light to light.
- R11: After a forced return to full power, the block stays in full power through idle cycles until a new set-state command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Decoded command present this cycle |
| cmdType | input | 3 | Command type: 1 set voltage, 2 set state |
| cmdByte | input | 8 | Command payload byte |
| ackValid | output | 1 | Acknowledge strobe, one cycle after cmdValid |
| ackCode | output | 2 | 2'b00 accepted, 2'b11 refused |
| powerState | output | 2 | Current power state code |
| vidCode | output | 8 | Current voltage target code |
| phaseShedEn | output | 1 | Phase shedding enable |
| pulseSkipEn | output | 1 | Pulse skipping enable |
| slewDone | output | 1 | Modelled voltage has reached the target |

## Verification
The assertions check several things on every cycle: the acknowledge strobe follows the command strobe by one clock, a refused command leaves the state and target untouched, a raising voltage change lands in full power, the state never drops into a low-power state without a set-state command, and the modelled voltage moves by single steps. Other behaviour only the bench scenarios can show. These are the exact acknowledge code for each payload, direct transitions between every pair of states, the effect of a reduced support mask, and the slew duration in clocks for a given voltage step.

// File: rtl/vrps_pkg.sv
package vrps_pkg;

  localparam int BYTE_W = 8;
  localparam int TYPE_W = 3;

  localparam logic [TYPE_W-1:0] CMD_SET_VID = 3'd1;
  localparam logic [TYPE_W-1:0] CMD_SET_PS  = 3'd2;

  localparam logic [1:0] ACK_DONE   = 2'b00;
  localparam logic [1:0] ACK_REFUSE = 2'b11;

  typedef enum logic [1:0] {
    PS_FULL   = 2'd0,
    PS_LIGHT  = 2'd1,
    PS_VLIGHT = 2'd2
  } pstate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              cmdSeen;
    logic              refuse;
    logic              loadPs;
    logic              loadVid;
    logic              forceFull;
    pstate_e           nextPs;
    logic [BYTE_W-1:0] nextVid;
  } ctrlStrb_t;

endpackage

// File: rtl/vrps_ctrl.sv
module vrps_ctrl
  import vrps_pkg::*;
#(
  parameter logic [1:0] LOW_PS_MASK = 2'b11
) (
  input  logic              cmdValid,
  input  logic [TYPE_W-1:0] cmdType,
  input  logic [BYTE_W-1:0] cmdByte,
  input  pstate_e           curPs,
  input  logic [BYTE_W-1:0] curVid,
  output ctrlStrb_t         strb
);

  localparam int NUM_LOW = 2;

  // support table indexed by the low two payload bits
  logic [3:0] stateOk;
  assign stateOk[0] = 1'b1;
  assign stateOk[3] = 1'b0;
  for (genvar g = 1; g <= NUM_LOW; g++) begin : g_support
    assign stateOk[g] = LOW_PS_MASK[g-1];
  end

  logic psAllowed;
  assign psAllowed = (cmdByte[BYTE_W-1:2] == '0) && stateOk[cmdByte[1:0]];

  logic vidRaise;
  assign vidRaise = cmdByte > curVid;

  always_comb begin
    strb           = '0;
    strb.nextPs    = curPs;
    strb.nextVid   = curVid;
    if (cmdValid) begin
      strb.cmdSeen = 1'b1;
      case (cmdType)
        CMD_SET_PS: begin
          if (psAllowed) begin
            strb.loadPs = 1'b1;
            strb.nextPs = pstate_e'(cmdByte[1:0]);
          end else begin
            strb.refuse = 1'b1;
          end
        end
        CMD_SET_VID: begin
          strb.loadVid = 1'b1;
          strb.nextVid = cmdByte;
          if (vidRaise && (curPs != PS_FULL)) begin
            strb.forceFull = 1'b1;
            strb.nextPs    = PS_FULL;
          end
        end
        default: strb.refuse = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/vrps_datapath.sv
module vrps_datapath
  import vrps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrb_t         strb,
  output pstate_e           curPs,
  output logic [BYTE_W-1:0] curVid,
  output logic              ackValid,
  output logic [1:0]        ackCode,
  output logic              phaseShedEn,
  output logic              pulseSkipEn,
  output logic              slewDone
);

  pstate_e           psReg;
  logic [BYTE_W-1:0] vidTarget;
  logic [BYTE_W-1:0] vidActual;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psReg <= PS_FULL;
    end else if (strb.loadPs || strb.forceFull) begin
      psReg <= strb.nextPs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vidTarget <= '0;
    end else if (strb.loadVid) begin
      vidTarget <= strb.nextVid;
    end
  end

  // slew model: one code per clock toward the target
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vidActual <= '0;
    end else if (vidActual < vidTarget) begin
      vidActual <= vidActual + 1'b1;
    end else if (vidActual > vidTarget) begin
      vidActual <= vidActual - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ackValid <= 1'b0;
      ackCode  <= ACK_DONE;
    end else begin
      ackValid <= strb.cmdSeen;
      if (strb.cmdSeen) begin
        ackCode <= strb.refuse ? ACK_REFUSE : ACK_DONE;
      end
    end
  end

  assign curPs       = psReg;
  assign curVid      = vidTarget;
  assign phaseShedEn = (psReg == PS_LIGHT);
  assign pulseSkipEn = (psReg == PS_VLIGHT);
  assign slewDone    = (vidActual == vidTarget);

  // R3
  enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phaseShedEn && pulseSkipEn));

  // R4
  refuse_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.refuse |=> ($stable(psReg) && $stable(vidTarget)));

  // R6
  raise_forces_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.forceFull |=> (psReg == PS_FULL));

  // R11
  no_self_lowpower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadPs |=> (psReg == PS_FULL || $stable(psReg)));

  // R9
  slew_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vidActual < vidTarget) |=> (vidActual == $past(vidActual) + 1'b1));

endmodule

// File: rtl/vr_pstate_handler.sv
module vr_pstate_handler
  import vrps_pkg::*;
#(
  parameter logic [1:0] LOW_PS_MASK = 2'b11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [2:0]  cmdType,
  input  logic [7:0]  cmdByte,
  output logic        ackValid,
  output logic [1:0]  ackCode,
  output logic [1:0]  powerState,
  output logic [7:0]  vidCode,
  output logic        phaseShedEn,
  output logic        pulseSkipEn,
  output logic        slewDone
);

  ctrlStrb_t         strb;
  pstate_e           curPs;
  logic [BYTE_W-1:0] curVid;

  vrps_ctrl #(
    .LOW_PS_MASK(LOW_PS_MASK)
  ) i_ctrl (
    .cmdValid(cmdValid),
    .cmdType (cmdType),
    .cmdByte (cmdByte),
    .curPs   (curPs),
    .curVid  (curVid),
    .strb    (strb)
  );

  vrps_datapath i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .curPs      (curPs),
    .curVid     (curVid),
    .ackValid   (ackValid),
    .ackCode    (ackCode),
    .phaseShedEn(phaseShedEn),
    .pulseSkipEn(pulseSkipEn),
    .slewDone   (slewDone)
  );

  assign powerState = curPs;
  assign vidCode    = curVid;

  // R8
  ack_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> ackValid);

  // R8
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |=> !ackValid);

endmodule

// File: tb/test_vr_pstate_handler.sv
module test_vr_pstate_handler;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmdValid;
  logic [2:0] cmdType;
  logic [7:0] cmdByte;

  logic       ackValid, ackValidB;
  logic [1:0] ackCode, ackCodeB;
  logic [1:0] powerState, powerStateB;
  logic [7:0] vidCode, vidCodeB;
  logic       phaseShedEn, phaseShedEnB;
  logic       pulseSkipEn, pulseSkipEnB;
  logic       slewDone, slewDoneB;

  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  vr_pstate_handler #(.LOW_PS_MASK(2'b11)) i_vr_pstate_handler (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdByte(cmdByte), .ackValid(ackValid), .ackCode(ackCode),
    .powerState(powerState), .vidCode(vidCode), .phaseShedEn(phaseShedEn),
    .pulseSkipEn(pulseSkipEn), .slewDone(slewDone)
  );

  // only light load supported here
  vr_pstate_handler #(.LOW_PS_MASK(2'b01)) i_vr_pstate_handler_lite (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdByte(cmdByte), .ackValid(ackValidB), .ackCode(ackCodeB),
    .powerState(powerStateB), .vidCode(vidCodeB), .phaseShedEn(phaseShedEnB),
    .pulseSkipEn(pulseSkipEnB), .slewDone(slewDoneB)
  );

  typedef struct packed {
    logic [2:0] typ;
    logic [7:0] pay;
    logic [1:0] ack;
    logic [1:0] ps;
    logic [7:0] vid;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{3'd2, 8'h01, 2'b00, 2'd1, 8'h00},  // R2 full -> light
    '{3'd2, 8'h02, 2'b00, 2'd2, 8'h00},  // R10 light -> very light
    '{3'd2, 8'h01, 2'b00, 2'd1, 8'h00},  // R10 very light -> light
    '{3'd2, 8'h00, 2'b00, 2'd0, 8'h00},  // R2 back to full
    '{3'd2, 8'h02, 2'b00, 2'd2, 8'h00},  // R10 full -> very light
    '{3'd2, 8'h03, 2'b11, 2'd2, 8'h00},  // R4 undefined state
    '{3'd2, 8'hFF, 2'b11, 2'd2, 8'h00},  // R4 undefined state
    '{3'd0, 8'h01, 2'b11, 2'd2, 8'h00},  // R5 unknown type
    '{3'd1, 8'h00, 2'b00, 2'd2, 8'h00},  // R7 equal voltage
    '{3'd1, 8'h20, 2'b00, 2'd0, 8'h20},  // R6 raise forces full
    '{3'd7, 8'h02, 2'b11, 2'd0, 8'h20},  // R5 unknown type
    '{3'd2, 8'h01, 2'b00, 2'd1, 8'h20},  // R2 light again
    '{3'd1, 8'h10, 2'b00, 2'd1, 8'h10},  // R7 lower voltage
    '{3'd1, 8'h10, 2'b00, 2'd1, 8'h10},  // R7 equal voltage
    '{3'd1, 8'h11, 2'b00, 2'd0, 8'h11},  // R6 raise by one
    '{3'd2, 8'h00, 2'b00, 2'd0, 8'h11}   // R2 full
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkPs(input string req, input logic [1:0] exp);
    chk(req, {30'd0, powerState}, {30'd0, exp});
    chk({req, " R3 shed"}, {31'd0, phaseShedEn}, {31'd0, exp == 2'd1});
    chk({req, " R3 skip"}, {31'd0, pulseSkipEn}, {31'd0, exp == 2'd2});
  endtask

  // drive one command for one cycle, return after the acknowledging edge
  task automatic sendCmd(input logic [2:0] t, input logic [7:0] b);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdType  = t;
    cmdByte  = b;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdType  = 3'd0;
    cmdByte  = 8'd0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n    = 1'b0;
    cmdValid = 1'b0;
    cmdType  = 3'd0;
    cmdByte  = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkPs("R1 reset ps", 2'd0);
    chk("R1 reset vid", {24'd0, vidCode}, 32'd0);
    chk("R1 reset ackValid", {31'd0, ackValid}, 32'd0);
    chk("R1 reset slewDone", {31'd0, slewDone}, 32'd1);
    rst_n = 1'b1;

    // R4 support mask: second instance lacks very light load
    sendCmd(3'd2, 8'h02);
    chk("R4 mask ack", {30'd0, ackCodeB}, {30'd0, 2'b11});
    chk("R4 mask ps held", {30'd0, powerStateB}, 32'd0);
    chk("R4 mask skip off", {31'd0, pulseSkipEnB}, 32'd0);
    chk("R2 full ack", {30'd0, ackCode}, 32'd0);
    checkPs("R2 very light", 2'd2);
    sendCmd(3'd2, 8'h01);
    chk("R2 mask light ack", {30'd0, ackCodeB}, 32'd0);
    chk("R2 mask light ps", {30'd0, powerStateB}, 32'd1);
    sendCmd(3'd2, 8'h00);
    checkPs("R2 back to full", 2'd0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      sendCmd(VECS[i].typ, VECS[i].pay);
      chk("R8 ackValid", {31'd0, ackValid}, 32'd1);
      chk("R2 R4 R5 ackCode", {30'd0, ackCode}, {30'd0, VECS[i].ack});
      checkPs("R2 R6 R7 R10 state", VECS[i].ps);
      chk("R4 R6 R7 vid", {24'd0, vidCode}, {24'd0, VECS[i].vid});
      @(negedge clk);
      chk("R8 ack drops", {31'd0, ackValid}, 32'd0);
    end

    // R11 forced exit then idle
    sendCmd(3'd2, 8'h02);
    checkPs("R11 enter very light", 2'd2);
    sendCmd(3'd1, 8'h12);
    checkPs("R11 forced full", 2'd0);
    repeat (12) @(negedge clk);
    checkPs("R11 stays full", 2'd0);

    // R8 back-to-back commands
    @(negedge clk);
    cmdValid = 1'b1; cmdType = 3'd2; cmdByte = 8'h01;
    @(negedge clk);
    chk("R8 first ackValid", {31'd0, ackValid}, 32'd1);
    chk("R8 first ackCode", {30'd0, ackCode}, 32'd0);
    cmdType = 3'd2; cmdByte = 8'h07;
    @(negedge clk);
    cmdValid = 1'b0; cmdType = 3'd0; cmdByte = 8'd0;
    chk("R8 second ackValid", {31'd0, ackValid}, 32'd1);
    chk("R8 second ackCode", {30'd0, ackCode}, {30'd0, 2'b11});
    checkPs("R8 R4 state after pair", 2'd1);
    sendCmd(3'd2, 8'h00);

    // R9 slew timing
    begin
      int n;
      n = 0;
      while (!slewDone && n < 300) begin @(negedge clk); n++; end
      chk("R9 settled", {31'd0, slewDone}, 32'd1);
      sendCmd(3'd1, 8'h19);
      chk("R9 busy after raise", {31'd0, slewDone}, 32'd0);
      n = 0;
      while (!slewDone && n < 300) begin @(negedge clk); n++; end
      chk("R9 raise cycles", n, 32'd7);
      sendCmd(3'd1, 8'h15);
      chk("R9 busy after lower", {31'd0, slewDone}, 32'd0);
      n = 0;
      while (!slewDone && n < 300) begin @(negedge clk); n++; end
      chk("R9 lower cycles", n, 32'd4);
      checkPs("R7 lower keeps full", 2'd0);
    end

    summary();
  end

endmodule